// File: doc/BRIEF.md
# Predicated Vector-Element Issue Sequencer

This block turns one ordinary scalar instruction into a loop of scalar element operations. Vector behaviour comes from tags rather than from dedicated opcodes. The decoder supplies three register numbers: one destination and two sources. It also supplies a "vectorised" tag for each operand, a vector length and a predicate mask read from an integer register. The sequencer walks the element index from zero to the vector length minus one. For every element whose predicate bit is set, it sends one scalar micro-op to the downstream issue queue over a valid/ready handshake.

Each operand has its own register offset, and that offset steps with the element index only when the operand is tagged. An untagged operand keeps naming the same scalar register. One mechanism therefore covers the scalar-scalar, scalar-vector and vector-vector forms. The program counter is held while the loop runs. A one-cycle completion pulse tells the front end that it may advance.

Top module: `vseq_top`

## Requirements
- R1: A new instruction is accepted only while the sequencer is idle (`in_ready` high). `in_ready` stays low from the cycle after acceptance until the cycle after the `done` pulse.
- R2: The element loop visits indices 0 to VL-1 in increasing order. Each emitted micro-op reports its index on `out_elem`.
- R3: Element i emits a micro-op only if bit i of `in_pred` is set (bit 0 belongs to element 0). A masked-off element emits nothing and costs one cycle.
- R4: `out_rd` equals `in_rd + i` (modulo the register count) when tag bit 0 of `in_vec` is set, and equals `in_rd` otherwise.
- R5: `out_rs1` and `out_rs2` follow the same rule as R4, with base `in_rs1` under tag bit 1 and base `in_rs2` under tag bit 2, each independently.
- R6: Register offsets also advance across masked-off elements, so an emitted element i always uses offset i on its tagged operands.
- R7: `pc_stall` is high from the cycle after acceptance until the last element has been handled. It is low while idle and during the `done` cycle.
- R8: `done` is high for exactly one cycle, in the cycle after the last element is handled. With VL = 0 no micro-op is sent and `done` rises in the cycle right after acceptance.
- R9: While `out_valid` is high and `out_ready` is low, the loop holds and every micro-op field stays stable.
- R10: A VL above the maximum vector length is clamped to the maximum.
- R11: Every micro-op carries the accepted opcode unchanged.
- R12: A synchronous active-high reset returns the block to idle, with no micro-op valid, `done` low and `pc_stall` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Sequencer idle, instruction taken when in_valid is high |
| in_opcode | input | OP_W | Scalar opcode |
| in_rd | input | REG_W | Destination register base |
| in_rs1 | input | REG_W | First source register base |
| in_rs2 | input | REG_W | Second source register base |
| in_vec | input | 3 | Vectorised tags: bit 0 rd, bit 1 rs1, bit 2 rs2 |
| in_vl | input | VL_W | Vector length |
| in_pred | input | MAX_VL | Predicate mask, bit i enables element i |
| out_valid | output | 1 | Micro-op present |
| out_ready | input | 1 | Issue queue accepts micro-op |
| out_opcode | output | OP_W | Micro-op opcode |
| out_rd | output | REG_W | Micro-op destination register |
| out_rs1 | output | REG_W | Micro-op first source register |
| out_rs2 | output | REG_W | Micro-op second source register |
| out_elem | output | IDX_W | Element index of the micro-op |
| pc_stall | output | 1 | Hold program counter |
| done | output | 1 | One-cycle completion pulse |

## Verification
The in-RTL assertions check on every cycle that a stalled micro-op keeps its fields, that `done` never lasts two cycles, that an accepted instruction immediately stalls the PC or completes, that emitted indices stay below the latched length, and that untagged operands keep their base register. Which elements appear, their order, the register arithmetic across masked gaps, the clamp of oversized lengths and the exact cycle of `done` relative to the last handshake can only be shown by the bench. The bench sweeps every vector length, every tag combination, several predicate patterns and two backpressure patterns.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    localparam int DEF_OP_W   = 8;
    localparam int DEF_REG_W  = 5;
    localparam int DEF_MAX_VL = 8;

    localparam int N_OPND   = 3;
    localparam int OPND_RD  = 0;
    localparam int OPND_RS1 = 1;
    localparam int OPND_RS2 = 2;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_DONE = 2'd2
    } seq_state_e;

    function automatic int len_width(input int max_vl);
        return $clog2(max_vl + 1);
    endfunction

    function automatic int idx_width(input int max_vl);
        return (max_vl > 1) ? $clog2(max_vl) : 1;
    endfunction

endpackage

// File: rtl/vseq_loop_ctrl.sv
module vseq_loop_ctrl
    import vseq_pkg::*;
#(
    parameter int MAX_VL = DEF_MAX_VL,
    localparam int VL_W  = len_width(MAX_VL),
    localparam int IDX_W = idx_width(MAX_VL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [VL_W-1:0]   in_vl,
    input  logic [MAX_VL-1:0] in_pred,
    output logic              load,
    output logic              step,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [IDX_W-1:0]  elem_idx,
    output logic              pc_stall,
    output logic              done
);

    seq_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [VL_W-1:0]   vl_q;
    logic [MAX_VL-1:0] pred_q;
    logic [VL_W-1:0]   vl_eff;
    logic              cur_on;
    logic              last;

    assign vl_eff   = (in_vl > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : in_vl;
    assign in_ready = (state_q == SQ_IDLE);
    assign load     = in_valid && in_ready;
    assign cur_on   = pred_q[idx_q];
    assign out_valid = (state_q == SQ_RUN) && cur_on;
    assign step     = (state_q == SQ_RUN) && (!cur_on || out_ready);
    assign last     = (VL_W'(idx_q) == vl_q - VL_W'(1));
    assign elem_idx = idx_q;
    assign pc_stall = (state_q == SQ_RUN);
    assign done     = (state_q == SQ_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            idx_q   <= '0;
            vl_q    <= '0;
            pred_q  <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (load) begin
                        idx_q   <= '0;
                        vl_q    <= vl_eff;
                        pred_q  <= in_pred;
                        state_q <= (vl_eff == '0) ? SQ_DONE : SQ_RUN;
                    end
                end
                SQ_RUN: begin
                    if (step) begin
                        if (last) begin
                            state_q <= SQ_DONE;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                default: begin
                    state_q <= SQ_IDLE;
                    idx_q   <= '0;
                end
            endcase
        end
    end

    assert_hold_elem_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(elem_idx)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_accept_stalls_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (pc_stall || done));

    assert_elem_range_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (VL_W'(elem_idx) < vl_q));

endmodule

// File: rtl/vseq_reg_step.sv
module vseq_reg_step
    import vseq_pkg::*;
#(
    parameter int REG_W  = DEF_REG_W,
    parameter int MAX_VL = DEF_MAX_VL,
    localparam int IDX_W = idx_width(MAX_VL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [REG_W-1:0] base_in,
    input  logic             vec_in,
    output logic [REG_W-1:0] reg_out
);

    logic [REG_W-1:0] base_q;
    logic             vec_q;
    logic [IDX_W-1:0] off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            vec_q  <= 1'b0;
            off_q  <= '0;
        end else if (load) begin
            base_q <= base_in;
            vec_q  <= vec_in;
            off_q  <= '0;
        end else if (step && vec_q) begin
            off_q <= off_q + IDX_W'(1);
        end
    end

    assign reg_out = base_q + REG_W'(off_q);

    assert_scalar_fixed_R4: assert property (@(posedge clk) disable iff (rst)
        (!vec_q && !load) |=> (reg_out == $past(reg_out)));

endmodule

// File: rtl/vseq_top.sv
module vseq_top
    import vseq_pkg::*;
#(
    parameter int OP_W   = DEF_OP_W,
    parameter int REG_W  = DEF_REG_W,
    parameter int MAX_VL = DEF_MAX_VL,
    localparam int VL_W  = len_width(MAX_VL),
    localparam int IDX_W = idx_width(MAX_VL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [OP_W-1:0]   in_opcode,
    input  logic [REG_W-1:0]  in_rd,
    input  logic [REG_W-1:0]  in_rs1,
    input  logic [REG_W-1:0]  in_rs2,
    input  logic [2:0]        in_vec,
    input  logic [VL_W-1:0]   in_vl,
    input  logic [MAX_VL-1:0] in_pred,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OP_W-1:0]   out_opcode,
    output logic [REG_W-1:0]  out_rd,
    output logic [REG_W-1:0]  out_rs1,
    output logic [REG_W-1:0]  out_rs2,
    output logic [IDX_W-1:0]  out_elem,
    output logic              pc_stall,
    output logic              done
);

    logic load;
    logic step;
    logic [OP_W-1:0] opcode_q;
    logic [N_OPND-1:0][REG_W-1:0] base_vec;
    logic [N_OPND-1:0][REG_W-1:0] reg_vec;

    vseq_loop_ctrl #(.MAX_VL(MAX_VL)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_vl     (in_vl),
        .in_pred   (in_pred),
        .load      (load),
        .step      (step),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .elem_idx  (out_elem),
        .pc_stall  (pc_stall),
        .done      (done)
    );

    assign base_vec[OPND_RD]  = in_rd;
    assign base_vec[OPND_RS1] = in_rs1;
    assign base_vec[OPND_RS2] = in_rs2;

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        vseq_reg_step #(.REG_W(REG_W), .MAX_VL(MAX_VL)) step_i (
            .clk     (clk),
            .rst     (rst),
            .load    (load),
            .step    (step),
            .base_in (base_vec[g]),
            .vec_in  (in_vec[g]),
            .reg_out (reg_vec[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            opcode_q <= '0;
        end else if (load) begin
            opcode_q <= in_opcode;
        end
    end

    assign out_opcode = opcode_q;
    assign out_rd     = reg_vec[OPND_RD];
    assign out_rs1    = reg_vec[OPND_RS1];
    assign out_rs2    = reg_vec[OPND_RS2];

    assert_hold_fields_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> ($stable(out_rd) && $stable(out_rs1)
                                       && $stable(out_rs2) && $stable(out_opcode)));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (!out_valid && !pc_stall));

endmodule

// File: tb/vseq_top_tb_top.sv
module vseq_top_tb_top;

    localparam int OP_W = 8, REG_W = 5, MAX_VL = 8;
    localparam int VL_W = 4, IDX_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [OP_W-1:0] in_opcode = '0;
    logic [REG_W-1:0] in_rd = '0, in_rs1 = '0, in_rs2 = '0;
    logic [2:0] in_vec = '0;
    logic [VL_W-1:0] in_vl = '0;
    logic [MAX_VL-1:0] in_pred = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [OP_W-1:0] out_opcode;
    logic [REG_W-1:0] out_rd, out_rs1, out_rs2;
    logic [IDX_W-1:0] out_elem;
    logic pc_stall, done;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vseq_top #(.OP_W(OP_W), .REG_W(REG_W), .MAX_VL(MAX_VL)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_opcode(in_opcode), .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
        .in_vec(in_vec), .in_vl(in_vl), .in_pred(in_pred),
        .out_valid(out_valid), .out_ready(out_ready), .out_opcode(out_opcode),
        .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2), .out_elem(out_elem),
        .pc_stall(pc_stall), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [REG_W-1:0] exp_reg(input logic [REG_W-1:0] b, input bit v, input int i);
        return v ? REG_W'(b + REG_W'(i)) : b;
    endfunction

    // Issue one instruction and follow it to completion; bp selects backpressure pattern.
    task automatic run_instr(input logic [OP_W-1:0] op, input logic [REG_W-1:0] rd,
                             input logic [REG_W-1:0] r1, input logic [REG_W-1:0] r2,
                             input logic [2:0] vec, input int vl, input logic [MAX_VL-1:0] pred,
                             input int bp);
        int vle, nexp, nops, next_i, n;
        bit pv, pr, fin;
        logic [REG_W-1:0] p_rd, p_r1, p_r2;
        logic [IDX_W-1:0] p_el;
        vle = (vl > MAX_VL) ? MAX_VL : vl;
        nexp = 0;
        for (int k = 0; k < vle; k++) if (pred[k]) nexp++;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 idle ready", int'(in_ready), 1);
        in_valid = 1'b1; in_opcode = op; in_rd = rd; in_rs1 = r1; in_rs2 = r2;
        in_vec = vec; in_vl = VL_W'(vl); in_pred = pred; out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        in_rd = ~rd; in_rs1 = ~r1; in_rs2 = ~r2; in_opcode = ~op;
        nops = 0; next_i = 0; pv = 0; pr = 0; fin = 0; n = 0;
        p_rd = '0; p_r1 = '0; p_r2 = '0; p_el = '0;
        while (!fin) begin
            n++;
            if (n > 200) begin
                chk(1'b0, "R8 completion timeout", n, 0);
                fin = 1;
            end else if (done) begin
                chk(nops == nexp, "R3 emitted count", nops, nexp);
                chk(pc_stall == 1'b0, "R7 stall low at done", int'(pc_stall), 0);
                chk(out_valid == 1'b0, "R8 no op at done", int'(out_valid), 0);
                if (vle == 0) chk(n == 1, "R8 zero length done cycle", n, 1);
                if (vle > 0 && bp == 0) chk(n == vle + 1, "R8 done after last element", n, vle + 1);
                out_ready = 1'b0;
                @(negedge clk);
                chk(done == 1'b0, "R8 done single cycle", int'(done), 0);
                chk(in_ready == 1'b1, "R1 idle after done", int'(in_ready), 1);
                fin = 1;
            end else begin
                chk(pc_stall == 1'b1, "R7 stall during loop", int'(pc_stall), 1);
                chk(in_ready == 1'b0, "R1 busy not ready", int'(in_ready), 0);
                if (pv && !pr) begin
                    chk(out_valid && out_elem == p_el && out_rd == p_rd && out_rs1 == p_r1
                        && out_rs2 == p_r2, "R9 held under backpressure", int'(out_elem), int'(p_el));
                end
                while (next_i < vle && !pred[next_i]) next_i++;
                if (out_valid) begin
                    chk(next_i < vle, "R3 op only for set bit", int'(out_elem), next_i);
                    chk(int'(out_elem) == next_i, "R2 element order", int'(out_elem), next_i);
                    chk(out_opcode == op, "R11 opcode", int'(out_opcode), int'(op));
                    chk(out_rd == exp_reg(rd, vec[0], next_i), "R4 R6 destination",
                        int'(out_rd), int'(exp_reg(rd, vec[0], next_i)));
                    chk(out_rs1 == exp_reg(r1, vec[1], next_i), "R5 R6 source one",
                        int'(out_rs1), int'(exp_reg(r1, vec[1], next_i)));
                    chk(out_rs2 == exp_reg(r2, vec[2], next_i), "R5 R6 source two",
                        int'(out_rs2), int'(exp_reg(r2, vec[2], next_i)));
                end
                out_ready = (bp == 0) ? 1'b1 : ((cyc % 3) != 1);
                pv = out_valid; pr = out_ready;
                p_rd = out_rd; p_r1 = out_rs1; p_r2 = out_rs2; p_el = out_elem;
                if (out_valid && out_ready) begin
                    nops++;
                    next_i++;
                end
                @(negedge clk);
            end
        end
    endtask

    initial begin : watchdog
        #1500000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [MAX_VL-1:0] preds [4];
        preds[0] = 8'hFF; preds[1] = 8'hA5; preds[2] = 8'h00; preds[3] = 8'h3C;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1, "R12 reset ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R12 reset no op", int'(out_valid), 0);
        chk(done == 1'b0, "R12 reset done low", int'(done), 0);
        chk(pc_stall == 1'b0, "R12 reset stall low", int'(pc_stall), 0);
        for (int vl = 0; vl <= MAX_VL; vl++)
            for (int p = 0; p < 4; p++)
                for (int v = 0; v < 8; v++)
                    run_instr(OP_W'(vl * 32 + p * 8 + v), 5'd3, 5'd29, 5'd17,
                              3'(v), vl, preds[p], (p + v) % 2);
        // R10: lengths beyond the maximum are clamped
        run_instr(8'h51, 5'd30, 5'd1, 5'd9, 3'b111, 9, 8'hFF, 0);
        run_instr(8'h52, 5'd30, 5'd1, 5'd9, 3'b101, 15, 8'h81, 1);
        // R3 R6: only the last element active, offsets still advance across gaps
        run_instr(8'h53, 5'd31, 5'd0, 5'd28, 3'b011, 8, 8'h80, 0);
        // R12: reset in the middle of a loop
        @(negedge clk);
        in_valid = 1'b1; in_vl = 4'd8; in_pred = 8'hFF; in_vec = 3'b111;
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(in_ready == 1'b1, "R12 mid-run reset idle", int'(in_ready), 1);
        chk(pc_stall == 1'b0 && out_valid == 1'b0, "R12 mid-run reset quiet",
            int'(pc_stall), 0);
        run_instr(8'h54, 5'd2, 5'd4, 5'd6, 3'b110, 3, 8'h07, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule